// File: doc/BRIEF.md
# Cascaded Interrupt Controller Acknowledge Glue

This block ties two 8-line interrupt controllers into one 16-line system. The secondary controller reports through line 2 of the primary. Each controller's request, mask and in-service vectors and its rotation base come in as inputs. The block resolves the best serviceable level of each controller. It drives one registered interrupt line to the CPU. When the CPU acknowledges, it returns an 8-bit vector and strobes each controller with the level that controller must move into service.

The block also covers the awkward corners of cascading. If the CPU acknowledges with nothing pending, it returns a spurious level. If line 2 of the primary is pending but the secondary has nothing left to serve (a stale cascade), the block drops line 2. The same happens when a mask write hides the interrupt that is in flight, and when a poll of the secondary finds a level. A controller re-initialisation forces the CPU line low. Register decoding and request capture stay inside the controllers, and the controllers act on the strobes this block issues.

Top module: `irq_cascade_ack`

## Requirements
- R1: After reset, every output is 0.
- R2: A controller has a pending level when some request bit is set and unmasked. The search for that level starts at its rotation base and moves upward modulo 8. The level is pending only if it ranks strictly above the highest-ranked in-service bit under the same rotation. `intr_o` reflects the primary's pending state one cycle after the inputs change.
- R3: `casc_set_o` is 1 in the cycle after any cycle in which the secondary has a pending level, and 0 otherwise.
- R4: One cycle after `inta_i`, `vec_vld_o` is 1 for exactly one cycle. If the primary's pending level L is not 2, then `pri_ack_o` is 1, `pri_ack_lvl_o` is L and `vec_o` is {`pri_base_i`, L}.
- R5: If the primary's pending level is 2 and the secondary has level S pending, an acknowledge strobes both controllers: the primary with level 2 and the secondary with level S. `vec_o` is then {`sec_base_i`, S}.
- R6: An acknowledge while the primary has nothing pending strobes neither controller, and `vec_o` is {`pri_base_i`, 7}.
- R7: An acknowledge while the primary's pending level is 2 and the secondary has nothing pending strobes only the primary (level 2). `vec_o` is then {`sec_base_i`, 7}.
- R8: When `pri_sfnm_i` is 1, in-service bit 2 of the primary is left out of the primary's in-service rank.
- R9: While the primary's pending level is 2 and the secondary has nothing pending, `intr_o` is 0 and `pri_clr_irr2_o` is 1, each one cycle later.
- R10: Two kinds of mask write hide the in-flight interrupt. One is a primary write (`pri_mask_we_i`) whose `mask_wdata_i` bit at the primary's pending level (not 2) is 1. The other is a secondary write whose bit at the secondary's level is 1 while the interrupt comes through line 2. Either one forces `intr_o` to 0 in the next cycle. If the hidden interrupt came from the secondary, `pri_clr_irr2_o` is also 1. A write that does not cover the in-flight level has no effect.
- R11: A poll of the secondary (`sec_poll_i`) that finds a pending level sets both `pri_clr_irr2_o` and `pri_clr_isr2_o` in the next cycle. A poll that finds nothing sets neither.
- R12: `pri_init_i` or `sec_init_i` forces `intr_o` to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_req_i | input | 8 | Primary request vector |
| pri_mask_i | input | 8 | Primary mask vector |
| pri_insvc_i | input | 8 | Primary in-service vector |
| pri_rot_i | input | 3 | Primary rotation base (top-priority line) |
| pri_sfnm_i | input | 1 | Primary special fully nested mode |
| sec_req_i | input | 8 | Secondary request vector |
| sec_mask_i | input | 8 | Secondary mask vector |
| sec_insvc_i | input | 8 | Secondary in-service vector |
| sec_rot_i | input | 3 | Secondary rotation base |
| pri_base_i | input | 5 | Primary vector base (upper vector bits) |
| sec_base_i | input | 5 | Secondary vector base (upper vector bits) |
| inta_i | input | 1 | CPU acknowledge strobe |
| pri_mask_we_i | input | 1 | Mask write to the primary this cycle |
| sec_mask_we_i | input | 1 | Mask write to the secondary this cycle |
| mask_wdata_i | input | 8 | Mask value being written |
| sec_poll_i | input | 1 | Poll read of the secondary this cycle |
| pri_init_i | input | 1 | Primary re-initialisation strobe |
| sec_init_i | input | 1 | Secondary re-initialisation strobe |
| intr_o | output | 1 | Interrupt line to the CPU |
| vec_o | output | 8 | Acknowledge vector |
| vec_vld_o | output | 1 | Vector valid |
| pri_ack_o | output | 1 | Move primary level into service |
| pri_ack_lvl_o | output | 3 | Level for the primary acknowledge |
| sec_ack_o | output | 1 | Move secondary level into service |
| sec_ack_lvl_o | output | 3 | Level for the secondary acknowledge |
| casc_set_o | output | 1 | Set strobe for primary request bit 2 |
| pri_clr_irr2_o | output | 1 | Clear primary request bit 2 |
| pri_clr_isr2_o | output | 1 | Clear primary in-service bit 2 |

## Verification
The bench builds the block with its default parameters: eight lines per controller and the cascade on line 2. At these values every level, rotation and vector base fits in a few directed patterns. Two kinds of level are driven: lines that sit above the cascade line and lines that sit below it. This brings several cases within reach: rotation that wraps past line 7, the stale-cascade clear with a lower line also waiting, and mask writes that do or do not cover the in-flight level of either controller.

// File: rtl/irq_cas_pkg.sv
package irq_cas_pkg;
  localparam int unsigned NLINE     = 8;
  localparam int unsigned LVL_W     = $clog2(NLINE);
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned BASE_W    = VEC_W - LVL_W;
  localparam int unsigned CASC_LINE = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t SPUR_LVL = lvl_t'(NLINE - 1);
  localparam lvl_t CASC_LVL = lvl_t'(CASC_LINE);
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_cas_pkg::*;
(
  input  logic [NLINE-1:0] vec_i,
  input  lvl_t             rot_i,
  output logic             hit_o,
  output lvl_t             rel_o
);
  // rel_o: distance from rotation base to the first set bit
  always_comb begin
    hit_o = |vec_i;
    rel_o = '0;
    for (int i = NLINE - 1; i >= 0; i--) begin
      if (vec_i[lvl_t'(rot_i + lvl_t'(i))]) rel_o = lvl_t'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl_resolve.sv
module irq_ctrl_resolve
  import irq_cas_pkg::*;
(
  input  logic [NLINE-1:0] req_i,
  input  logic [NLINE-1:0] mask_i,
  input  logic [NLINE-1:0] insvc_i,
  input  lvl_t             rot_i,
  input  logic             excl_casc_i,
  output logic             pend_o,
  output lvl_t             lvl_o
);
  localparam logic [NLINE-1:0] CASC_BIT = NLINE'(1) << CASC_LINE;

  logic [NLINE-1:0] live, busy;
  logic             live_hit, busy_hit;
  lvl_t             live_rel, busy_rel;

  assign live = req_i & ~mask_i;
  assign busy = insvc_i & ~(excl_casc_i ? CASC_BIT : '0);

  irq_prio_pick u_live (.vec_i(live), .rot_i(rot_i), .hit_o(live_hit), .rel_o(live_rel));
  irq_prio_pick u_busy (.vec_i(busy), .rot_i(rot_i), .hit_o(busy_hit), .rel_o(busy_rel));

  assign pend_o = live_hit && (!busy_hit || (live_rel < busy_rel));
  assign lvl_o  = lvl_t'(rot_i + live_rel);
endmodule

// File: rtl/irq_cascade_ack.sv
module irq_cascade_ack
  import irq_cas_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINE-1:0]  pri_req_i,
  input  logic [NLINE-1:0]  pri_mask_i,
  input  logic [NLINE-1:0]  pri_insvc_i,
  input  logic [LVL_W-1:0]  pri_rot_i,
  input  logic              pri_sfnm_i,
  input  logic [NLINE-1:0]  sec_req_i,
  input  logic [NLINE-1:0]  sec_mask_i,
  input  logic [NLINE-1:0]  sec_insvc_i,
  input  logic [LVL_W-1:0]  sec_rot_i,
  input  logic [BASE_W-1:0] pri_base_i,
  input  logic [BASE_W-1:0] sec_base_i,
  input  logic              inta_i,
  input  logic              pri_mask_we_i,
  input  logic              sec_mask_we_i,
  input  logic [NLINE-1:0]  mask_wdata_i,
  input  logic              sec_poll_i,
  input  logic              pri_init_i,
  input  logic              sec_init_i,
  output logic              intr_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_vld_o,
  output logic              pri_ack_o,
  output logic [LVL_W-1:0]  pri_ack_lvl_o,
  output logic              sec_ack_o,
  output logic [LVL_W-1:0]  sec_ack_lvl_o,
  output logic              casc_set_o,
  output logic              pri_clr_irr2_o,
  output logic              pri_clr_isr2_o
);
  localparam int unsigned NCTRL = 2;

  logic [NCTRL-1:0][NLINE-1:0] req_a, mask_a, insvc_a;
  lvl_t [NCTRL-1:0]            rot_a, lvl_a;
  logic [NCTRL-1:0]            pend_a, excl_a;

  assign req_a   = {sec_req_i,   pri_req_i};
  assign mask_a  = {sec_mask_i,  pri_mask_i};
  assign insvc_a = {sec_insvc_i, pri_insvc_i};
  assign rot_a   = {sec_rot_i,   pri_rot_i};
  assign excl_a  = {1'b0,        pri_sfnm_i};

  for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
    irq_ctrl_resolve u_res (
      .req_i      (req_a[g]),
      .mask_i     (mask_a[g]),
      .insvc_i    (insvc_a[g]),
      .rot_i      (rot_a[g]),
      .excl_casc_i(excl_a[g]),
      .pend_o     (pend_a[g]),
      .lvl_o      (lvl_a[g])
    );
  end

  logic pri_pend, sec_pend, via_casc, from_sec, stale;
  lvl_t pri_lvl, sec_lvl, pri_sel, sec_sel;
  logic hide_pri, hide_sec, intr_d;
  logic [VEC_W-1:0] vec_d;

  assign pri_pend = pend_a[0];
  assign sec_pend = pend_a[1];
  assign pri_lvl  = lvl_a[0];
  assign sec_lvl  = lvl_a[1];
  assign via_casc = pri_pend && (pri_lvl == CASC_LVL);
  assign from_sec = via_casc && sec_pend;
  assign stale    = via_casc && !sec_pend;
  assign pri_sel  = pri_pend ? pri_lvl : SPUR_LVL;
  assign sec_sel  = sec_pend ? sec_lvl : SPUR_LVL;

  // mask write covering the level currently in flight
  assign hide_pri = pri_mask_we_i && pri_pend && !via_casc && mask_wdata_i[pri_lvl];
  assign hide_sec = sec_mask_we_i && from_sec && mask_wdata_i[sec_lvl];

  assign intr_d = pri_pend && !stale && !hide_pri && !hide_sec && !pri_init_i && !sec_init_i;
  assign vec_d  = via_casc ? {sec_base_i, sec_sel} : {pri_base_i, pri_sel};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intr_o         <= 1'b0;
      vec_o          <= '0;
      vec_vld_o      <= 1'b0;
      pri_ack_o      <= 1'b0;
      pri_ack_lvl_o  <= '0;
      sec_ack_o      <= 1'b0;
      sec_ack_lvl_o  <= '0;
      casc_set_o     <= 1'b0;
      pri_clr_irr2_o <= 1'b0;
      pri_clr_isr2_o <= 1'b0;
    end else begin
      intr_o         <= intr_d;
      vec_vld_o      <= inta_i;
      vec_o          <= inta_i ? vec_d : '0;
      pri_ack_o      <= inta_i && pri_pend;
      pri_ack_lvl_o  <= inta_i ? pri_sel : '0;
      sec_ack_o      <= inta_i && from_sec;
      sec_ack_lvl_o  <= (inta_i && from_sec) ? sec_lvl : '0;
      casc_set_o     <= sec_pend;
      pri_clr_irr2_o <= stale || hide_sec || (sec_poll_i && sec_pend);
      pri_clr_isr2_o <= sec_poll_i && sec_pend;
    end
  end
endmodule

// File: rtl/irq_cascade_ack_chk.sv
module irq_cascade_ack_chk
  import irq_cas_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             inta_i,
  input logic             vec_vld_o,
  input logic [LVL_W-1:0] vec_lo,
  input logic             pri_ack_o,
  input logic [LVL_W-1:0] pri_ack_lvl_o,
  input logic             sec_ack_o,
  input logic             intr_o,
  input logic             pri_init_i,
  input logic             sec_init_i,
  input logic             sec_poll_i,
  input logic             pri_clr_irr2_o,
  input logic             pri_clr_isr2_o
);
  p_vec_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> vec_vld_o);
  p_vec_needs_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> $past(inta_i));
  p_sec_via_line2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_ack_o |-> (pri_ack_o && pri_ack_lvl_o == CASC_LVL));
  p_spurious_seven_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_vld_o && !pri_ack_o) |-> (vec_lo == SPUR_LVL));
  p_init_drops_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_init_i || sec_init_i) |=> !intr_o);
  p_poll_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_clr_isr2_o |-> (pri_clr_irr2_o && $past(sec_poll_i)));
endmodule

bind irq_cascade_ack irq_cascade_ack_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .inta_i        (inta_i),
  .vec_vld_o     (vec_vld_o),
  .vec_lo        (vec_o[2:0]),
  .pri_ack_o     (pri_ack_o),
  .pri_ack_lvl_o (pri_ack_lvl_o),
  .sec_ack_o     (sec_ack_o),
  .intr_o        (intr_o),
  .pri_init_i    (pri_init_i),
  .sec_init_i    (sec_init_i),
  .sec_poll_i    (sec_poll_i),
  .pri_clr_irr2_o(pri_clr_irr2_o),
  .pri_clr_isr2_o(pri_clr_isr2_o)
);

// File: tb/irq_cascade_ack_test.sv
module irq_cascade_ack_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] pri_req_i = '0, pri_mask_i = '0, pri_insvc_i = '0;
  logic [7:0] sec_req_i = '0, sec_mask_i = '0, sec_insvc_i = '0, mask_wdata_i = '0;
  logic [2:0] pri_rot_i = '0, sec_rot_i = '0;
  logic [4:0] pri_base_i = 5'h01, sec_base_i = 5'h0E;
  logic pri_sfnm_i = 0, inta_i = 0, pri_mask_we_i = 0, sec_mask_we_i = 0;
  logic sec_poll_i = 0, pri_init_i = 0, sec_init_i = 0;
  logic intr_o, vec_vld_o, pri_ack_o, sec_ack_o, casc_set_o, pri_clr_irr2_o, pri_clr_isr2_o;
  logic [7:0] vec_o;
  logic [2:0] pri_ack_lvl_o, sec_ack_lvl_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  irq_cascade_ack uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    pri_req_i = '0; pri_mask_i = '0; pri_insvc_i = '0; pri_rot_i = '0; pri_sfnm_i = 0;
    sec_req_i = '0; sec_mask_i = '0; sec_insvc_i = '0; sec_rot_i = '0;
    inta_i = 0; pri_mask_we_i = 0; sec_mask_we_i = 0; mask_wdata_i = '0;
    sec_poll_i = 0; pri_init_i = 0; sec_init_i = 0;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 intr", intr_o, 0);
    chk("R1 vld", vec_vld_o, 0);
    chk("R1 acks", {pri_ack_o, sec_ack_o, casc_set_o, pri_clr_irr2_o, pri_clr_isr2_o}, 0);
  endtask

  task automatic t_ack_primary();
    idle();
    pri_req_i = 8'h21; tick();
    chk("R2 intr raised", intr_o, 1);
    inta_i = 1; tick();
    chk("R4 vld", vec_vld_o, 1);
    chk("R4 vec", vec_o, 8'h08);
    chk("R4 pri ack", {pri_ack_o, pri_ack_lvl_o}, {1'b1, 3'd0});
    chk("R4 no sec ack", sec_ack_o, 0);
    inta_i = 0; tick();
    chk("R4 vld single", vec_vld_o, 0);
  endtask

  task automatic t_priority();
    idle();
    pri_rot_i = 3'd3; pri_req_i = 8'h21; inta_i = 1; tick();
    chk("R2 rotated lvl", pri_ack_lvl_o, 5);
    chk("R2 rotated vec", vec_o, 8'h0D);
    inta_i = 0;
    pri_rot_i = 3'd0; pri_insvc_i = 8'h02; pri_req_i = 8'h10; tick();
    chk("R2 blocked by insvc", intr_o, 0);
    pri_req_i = 8'h11; tick();
    chk("R2 above insvc", intr_o, 1);
    pri_insvc_i = 8'h00; pri_req_i = 8'h01; pri_mask_i = 8'h01; tick();
    chk("R2 masked", intr_o, 0);
  endtask

  task automatic t_cascade();
    idle();
    pri_req_i = 8'h04; sec_req_i = 8'h08; tick();
    chk("R3 casc set", casc_set_o, 1);
    chk("R5 intr", intr_o, 1);
    inta_i = 1; tick();
    chk("R5 pri ack", {pri_ack_o, pri_ack_lvl_o}, {1'b1, 3'd2});
    chk("R5 sec ack", {sec_ack_o, sec_ack_lvl_o}, {1'b1, 3'd3});
    chk("R5 vec", vec_o, 8'h73);
    inta_i = 0; sec_req_i = 8'h00; tick();
    chk("R3 casc clear", casc_set_o, 0);
  endtask

  task automatic t_spur_pri();
    idle();
    inta_i = 1; tick();
    chk("R6 vld", vec_vld_o, 1);
    chk("R6 vec", vec_o, 8'h0F);
    chk("R6 no acks", {pri_ack_o, sec_ack_o}, 0);
  endtask

  task automatic t_stale();
    idle();
    pri_req_i = 8'h14; tick();
    chk("R9 intr low", intr_o, 0);
    chk("R9 clr irr2", pri_clr_irr2_o, 1);
    inta_i = 1; tick();
    chk("R7 pri ack", {pri_ack_o, pri_ack_lvl_o}, {1'b1, 3'd2});
    chk("R7 no sec ack", sec_ack_o, 0);
    chk("R7 vec", vec_o, 8'h77);
  endtask

  task automatic t_nested();
    idle();
    pri_req_i = 8'h04; pri_insvc_i = 8'h04; sec_req_i = 8'h02; tick();
    chk("R8 off blocks", intr_o, 0);
    pri_sfnm_i = 1; tick();
    chk("R8 on passes", intr_o, 1);
  endtask

  task automatic t_mask_hide();
    idle();
    pri_req_i = 8'h10; tick();
    chk("R10 pre", intr_o, 1);
    pri_mask_we_i = 1; mask_wdata_i = 8'h40; tick();
    chk("R10 miss keeps", intr_o, 1);
    mask_wdata_i = 8'h10; tick();
    chk("R10 pri hide", intr_o, 0);
    chk("R10 pri no clr", pri_clr_irr2_o, 0);
    pri_mask_we_i = 0; pri_req_i = 8'h04; sec_req_i = 8'h20; tick();
    chk("R10 sec pre", intr_o, 1);
    sec_mask_we_i = 1; mask_wdata_i = 8'h20; tick();
    chk("R10 sec hide", intr_o, 0);
    chk("R10 sec clr", pri_clr_irr2_o, 1);
  endtask

  task automatic t_poll();
    idle();
    sec_req_i = 8'h02; sec_poll_i = 1; tick();
    chk("R11 clr irr2", pri_clr_irr2_o, 1);
    chk("R11 clr isr2", pri_clr_isr2_o, 1);
    sec_req_i = 8'h00; tick();
    chk("R11 empty", {pri_clr_irr2_o, pri_clr_isr2_o}, 0);
  endtask

  task automatic t_init();
    idle();
    pri_req_i = 8'h01; tick();
    chk("R12 pre", intr_o, 1);
    pri_init_i = 1; tick();
    chk("R12 pri init", intr_o, 0);
    pri_init_i = 0; tick();
    chk("R12 recover", intr_o, 1);
    sec_init_i = 1; tick();
    chk("R12 sec init", intr_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    tick();
    t_reset();
    t_ack_primary();
    t_priority();
    t_cascade();
    t_spur_pri();
    t_stale();
    t_nested();
    t_mask_hide();
    t_poll();
    t_init();
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule